// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Overlap Guard

This block is the synchronous control core that sits in front of a pair of half-bridge gate drivers. It takes its command either as two separate high-true requests (one for the high-side switch, one for the low-side switch) or as one PWM line, selected by a mode input. It produces two gate-enable outputs: `gate_a` for the high side and `gate_b` for the low side.

Between the fall of one output and the rise of the other, the block holds off the rising edge for a programmable number of clock cycles. It never lets both outputs be high together. A force-off input and a supply permit input both take precedence over the commands and pull both outputs low. Isolation, drive strength and supply sensing are handled elsewhere. Their combined verdict arrives as the single `permit` signal.

The dead-time count comes from an 8-bit configuration input. A zero value selects a one-cycle floor. Values above the cap of 220 are clamped to 220. Falling edges are never delayed.

Top module: `hbd_gate_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both `gate_a` and `gate_b` read 0.
- R2: With `mode_pwm` = 0 (two-input mode), `cmd_hi` = 1 requests `gate_a` high and `cmd_lo` = 1 requests `gate_b` high. The inputs are non-inverting.
- R3: With `mode_pwm` = 1, `cmd_pwm` = 1 requests `gate_a` high and `gate_b` low. `cmd_pwm` = 0 requests `gate_a` low and `gate_b` high. `cmd_hi` and `cmd_lo` are ignored in this mode.
- R4: `gate_a` and `gate_b` are never 1 in the same cycle.
- R5: In two-input mode, `cmd_hi` = `cmd_lo` = 1 drives both outputs to 0 on the next clock edge. They stay at 0 while the overlap lasts. The first rise after the overlap ends still waits the full dead time.
- R6: `force_off` = 1 drives both outputs to 0 on the next edge, whatever the commands are. After it returns to 0, operation resumes, and each rise waits the dead time.
- R7: `permit` = 0 overrides every other input and drives both outputs to 0 on the next edge.
- R8: Let D be the effective dead time. An output rises only after its request has been present for D consecutive clock edges at which the other output register already read 0. Consequences:
  - Starting from both outputs low, the output is high D edges after the request appears.
  - Starting from the other output high, the output is high D+1 edges after the request switches.
- R9: `dt_cfg` = 0 gives an effective dead time of D = 1. Values from 1 to 220 are used as given.
- R10: `dt_cfg` values above 220 are clamped, so D = 220.
- R11: An output falls on the first clock edge after its request goes away, with no dead-time delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| permit | input | 1 | Supply supervisor permit; 0 forces both outputs low |
| force_off | input | 1 | 1 forces both outputs low |
| mode_pwm | input | 1 | 0 = two-input mode, 1 = single PWM input mode |
| cmd_hi | input | 1 | High-side request (two-input mode) |
| cmd_lo | input | 1 | Low-side request (two-input mode) |
| cmd_pwm | input | 1 | PWM request (PWM mode) |
| dt_cfg | input | 8 | Dead-time count in clock cycles (0 = floor of 1, capped at 220) |
| gate_a | output | 1 | High-side gate enable |
| gate_b | output | 1 | Low-side gate enable |

## Verification
The assertions check the following on every cycle:
- the two outputs are never high together;
- the next-edge shutdown caused by `permit`, `force_off` and an input overlap;
- the one-edge fall after a request is dropped;
- an output never rises in the cycle straight after its peer was high.

The exact rise latency cannot be seen by a property over a window this long. That includes the zero floor, the 220 clamp, and the full wait after an overlap or a force-off clears. These are shown by the bench's timed scenarios and by the cycle-by-cycle reference model, which it follows through directed and randomised traffic in both modes.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int HBD_DT_W     = 8;
    localparam int HBD_DT_CAP   = 220;
    localparam int HBD_DT_FLOOR = 1;

    typedef enum logic {
        SRC_PAIR = 1'b0,
        SRC_PWM  = 1'b1
    } src_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_req_t;

    // Map raw command inputs to a per-side request according to the mode.
    function automatic gate_req_t route_cmd(
        input src_mode_e mode,
        input logic      hi,
        input logic      lo,
        input logic      pwm
    );
        gate_req_t r;
        if (mode == SRC_PWM) begin
            r.hi = pwm;
            r.lo = ~pwm;
        end else begin
            r.hi = hi;
            r.lo = lo;
        end
        return r;
    endfunction

    // Two-input mode asks for both switches at once.
    function automatic logic is_overlap(
        input src_mode_e mode,
        input logic      hi,
        input logic      lo
    );
        return (mode == SRC_PAIR) && hi && lo;
    endfunction

endpackage

// File: rtl/hbd_req_decode.sv
module hbd_req_decode
    import hbd_pkg::*;
(
    input  logic      permit,
    input  logic      force_off,
    input  logic      mode_pwm,
    input  logic      cmd_hi,
    input  logic      cmd_lo,
    input  logic      cmd_pwm,
    output gate_req_t req
);
    src_mode_e mode;
    gate_req_t routed;
    logic      blocked;

    always_comb begin
        mode    = src_mode_e'(mode_pwm);
        routed  = route_cmd(mode, cmd_hi, cmd_lo, cmd_pwm);
        blocked = force_off | ~permit | is_overlap(mode, cmd_hi, cmd_lo);
        req     = blocked ? '0 : routed;
    end

endmodule

// File: rtl/hbd_dt_norm.sv
module hbd_dt_norm #(
    parameter int DT_W     = 8,
    parameter int DT_CAP   = 220,
    parameter int DT_FLOOR = 1
) (
    input  logic [DT_W-1:0] dt_cfg,
    output logic [DT_W-1:0] dt_eff
);
    localparam logic [DT_W-1:0] CAP_V   = DT_W'(DT_CAP);
    localparam logic [DT_W-1:0] FLOOR_V = DT_W'(DT_FLOOR);

    always_comb begin
        if (dt_cfg == '0) begin
            dt_eff = FLOOR_V;
        end else if (dt_cfg > CAP_V) begin
            dt_eff = CAP_V;
        end else begin
            dt_eff = dt_cfg;
        end
    end

endmodule

// File: rtl/hbd_edge_gate.sv
module hbd_edge_gate #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            peer_on,
    input  logic [DT_W-1:0] dt_eff,
    output logic            gate_on
);
    logic [DT_W-1:0] wait_cnt;
    logic [DT_W:0]   wait_nxt;

    assign wait_nxt = {1'b0, wait_cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_on  <= 1'b0;
            wait_cnt <= '0;
        end else if (!req) begin
            // falling edge is never delayed
            gate_on  <= 1'b0;
            wait_cnt <= '0;
        end else if (peer_on) begin
            // peer still conducting: the gap has not started yet
            gate_on  <= 1'b0;
            wait_cnt <= '0;
        end else if (!gate_on) begin
            if (wait_nxt >= {1'b0, dt_eff}) begin
                gate_on <= 1'b1;
            end else begin
                wait_cnt <= wait_nxt[DT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/hbd_gate_ctrl.sv
module hbd_gate_ctrl
    import hbd_pkg::*;
#(
    parameter int DT_W     = HBD_DT_W,
    parameter int DT_CAP   = HBD_DT_CAP,
    parameter int DT_FLOOR = HBD_DT_FLOOR
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            permit,
    input  logic            force_off,
    input  logic            mode_pwm,
    input  logic            cmd_hi,
    input  logic            cmd_lo,
    input  logic            cmd_pwm,
    input  logic [DT_W-1:0] dt_cfg,
    output logic            gate_a,
    output logic            gate_b
);
    localparam int N_SIDE = 2;

    gate_req_t         req;
    logic [DT_W-1:0]   dt_eff;
    logic [N_SIDE-1:0] side_req;
    logic [N_SIDE-1:0] side_on;

    hbd_req_decode u_dec (
        .permit    (permit),
        .force_off (force_off),
        .mode_pwm  (mode_pwm),
        .cmd_hi    (cmd_hi),
        .cmd_lo    (cmd_lo),
        .cmd_pwm   (cmd_pwm),
        .req       (req)
    );

    hbd_dt_norm #(
        .DT_W     (DT_W),
        .DT_CAP   (DT_CAP),
        .DT_FLOOR (DT_FLOOR)
    ) u_norm (
        .dt_cfg (dt_cfg),
        .dt_eff (dt_eff)
    );

    assign side_req = {req.lo, req.hi};

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        hbd_edge_gate #(
            .DT_W (DT_W)
        ) u_gate (
            .clk     (clk),
            .rst     (rst),
            .req     (side_req[s]),
            .peer_on (side_on[N_SIDE-1-s]),
            .dt_eff  (dt_eff),
            .gate_on (side_on[s])
        );
    end

    assign gate_a = side_on[0];
    assign gate_b = side_on[1];

endmodule

// File: rtl/hbd_gate_chk.sv
module hbd_gate_chk (
    input logic clk,
    input logic rst,
    input logic permit,
    input logic force_off,
    input logic mode_pwm,
    input logic cmd_hi,
    input logic cmd_lo,
    input logic gate_a,
    input logic gate_b
);
    // R4
    both_high_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_a && gate_b));

    // R7
    permit_low_chk: assert property (@(posedge clk) disable iff (rst)
        !permit |=> (!gate_a && !gate_b));

    // R6
    force_off_chk: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (!gate_a && !gate_b));

    // R5
    overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_pwm && cmd_hi && cmd_lo) |=> (!gate_a && !gate_b));

    // R11
    fall_a_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_pwm && !cmd_hi) |=> !gate_a);

    // R8
    gap_a_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_a) |-> !$past(gate_b));

    // R8
    gap_b_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_b) |-> !$past(gate_a));

endmodule

bind hbd_gate_ctrl hbd_gate_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .permit    (permit),
    .force_off (force_off),
    .mode_pwm  (mode_pwm),
    .cmd_hi    (cmd_hi),
    .cmd_lo    (cmd_lo),
    .gate_a    (gate_a),
    .gate_b    (gate_b)
);

// File: tb/hbd_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module hbd_gate_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       permit = 1'b1, force_off = 1'b0, mode_pwm = 1'b0;
    logic       cmd_hi = 1'b0, cmd_lo = 1'b0, cmd_pwm = 1'b0;
    logic [7:0] dt_cfg = 8'd3;
    logic       gate_a, gate_b;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;
    string tag = "R2";

    // reference model state
    bit ma = 0, mb = 0;
    int ca = 0, cb = 0;

    always #10 clk = ~clk;

    hbd_gate_ctrl dut_i (
        .clk(clk), .rst(rst), .permit(permit), .force_off(force_off),
        .mode_pwm(mode_pwm), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .cmd_pwm(cmd_pwm), .dt_cfg(dt_cfg), .gate_a(gate_a), .gate_b(gate_b)
    );

    // behavioural model of the requirements
    always @(posedge clk) begin
        bit ra, rb, blk, na, nb;
        int d;
        if (rst) begin
            ma = 0; mb = 0; ca = 0; cb = 0;
        end else begin
            if (mode_pwm) begin ra = cmd_pwm; rb = !cmd_pwm; end
            else          begin ra = cmd_hi;  rb = cmd_lo;   end
            blk = force_off || !permit || (!mode_pwm && cmd_hi && cmd_lo);
            if (blk) begin ra = 0; rb = 0; end
            d = (dt_cfg == 0) ? 1 : ((dt_cfg > 220) ? 220 : int'(dt_cfg));
            na = ma; nb = mb;
            if (!ra || mb) begin na = 0; ca = 0; end
            else if (!ma) begin
                if (ca + 1 >= d) na = 1; else ca = ca + 1;
            end
            if (!rb || ma) begin nb = 0; cb = 0; end
            else if (!mb) begin
                if (cb + 1 >= d) nb = 1; else cb = cb + 1;
            end
            ma = na; mb = nb;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(gate_a == ma && gate_b == mb, tag, "model compare {a,b}",
                  {gate_a, gate_b}, {ma, mb});
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high(input bit side_b, input int exp, input string req);
        int n = 0;
        do begin
            tick();
            n++;
        end while (((side_b ? gate_b : gate_a) == 1'b0) && n < 400);
        check(n == exp, req, "rise latency", n, exp);
    endtask

    // switch from low side high to high side, measure the rise of gate_a
    task automatic swap_latency(input logic [7:0] cfg, input int exp, input string req);
        tag = req;
        dt_cfg = cfg; mode_pwm = 0; cmd_hi = 0; cmd_lo = 1;
        tick(240);
        check(gate_b == 1, req, "gate_b settled high", gate_b, 1);
        cmd_lo = 0; cmd_hi = 1;
        wait_high(1'b0, exp, req);
    endtask

    initial begin : main
        tick(3);
        // R1 reset state
        check(gate_a == 0 && gate_b == 0, "R1", "outputs in reset", {gate_a, gate_b}, 0);
        rst = 0;
        tick();
        check(gate_a == 0 && gate_b == 0, "R1", "outputs after reset", {gate_a, gate_b}, 0);

        // R2 two-input mapping, from idle D edges
        tag = "R2"; dt_cfg = 8'd3; cmd_hi = 1;
        wait_high(1'b0, 3, "R2");
        check(gate_b == 0, "R2", "gate_b low while cmd_hi", gate_b, 0);
        // R11 fall without delay
        cmd_hi = 0; tick();
        check(gate_a == 0, "R11", "gate_a falls next edge", gate_a, 0);
        cmd_lo = 1;
        wait_high(1'b1, 3, "R2");

        // R8 swap latency D+1
        swap_latency(8'd5, 6, "R8");
        // R9 zero selects one cycle
        swap_latency(8'd0, 2, "R9");
        // R10 clamp
        swap_latency(8'd250, 221, "R10");
        swap_latency(8'd220, 221, "R10");

        // R5 overlap then release with full dead time
        tag = "R5"; dt_cfg = 8'd4; cmd_hi = 1; cmd_lo = 0; tick(10);
        cmd_lo = 1; tick();
        check(gate_a == 0 && gate_b == 0, "R5", "overlap forces low", {gate_a, gate_b}, 0);
        tick(5);
        cmd_lo = 0;
        wait_high(1'b0, 4, "R5");

        // R6 force_off
        tag = "R6"; force_off = 1; tick();
        check(gate_a == 0 && gate_b == 0, "R6", "force_off low", {gate_a, gate_b}, 0);
        tick(4);
        force_off = 0;
        wait_high(1'b0, 4, "R6");

        // R7 permit overrides force_off release and commands
        tag = "R7"; permit = 0; tick();
        check(gate_a == 0 && gate_b == 0, "R7", "permit low", {gate_a, gate_b}, 0);
        tick(6);
        check(gate_a == 0, "R7", "held low", gate_a, 0);
        permit = 1;
        wait_high(1'b0, 4, "R7");
        cmd_hi = 0; tick(6);

        // R3 PWM mode, cmd_hi/cmd_lo ignored
        tag = "R3"; mode_pwm = 1; cmd_hi = 1; cmd_lo = 1; dt_cfg = 8'd3;
        cmd_pwm = 0; tick(8);
        check(gate_b == 1 && gate_a == 0, "R3", "pwm low -> b", {gate_a, gate_b}, 1);
        cmd_pwm = 1;
        wait_high(1'b0, 4, "R3");
        check(gate_b == 0, "R3", "pwm high -> b low", gate_b, 0);
        for (int p = 1; p < 8; p++) begin
            cmd_pwm = ~cmd_pwm; tick(p);
            cmd_pwm = ~cmd_pwm; tick(p + 3);
        end

        // R4 randomised traffic in both modes, model compared each cycle
        tag = "R4";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom();
            mode_pwm  = r[0] & r[1];
            cmd_hi    = r[2];
            cmd_lo    = r[3] & r[4];
            cmd_pwm   = r[5] | r[6];
            force_off = (r[11:7] == 0);
            permit    = (r[16:12] != 0);
            if (i % 97 == 0) dt_cfg = 8'(r[20:18]);
            if (r[21]) tick(1 + int'(r[24:22]));
            else tick();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule